// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters handed over by a host into a start/stop framed bit stream on one output line. The line sits high between characters. Each character goes out as a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit of even or odd sense, then one or two high stop bits. The framing is chosen at run time through four configuration inputs. The block takes a snapshot of these inputs when a character enters the shift register, so it is safe to change them while a frame is being sent.

The block does not generate a baud rate. A sample-tick enable comes from outside, and every bit on the line lasts exactly `OVERSAMPLE` ticks, 16 by default, which matches a receiver that samples at 16 times the bit rate. A one-entry holding register sits in front of the shift register. The host can therefore write the next character while the current one is still being sent, and that character then follows with no idle gap. `ready` is high when the holding register is empty and can be used directly as an interrupt request. `busy` covers both the holding register and the shift register. A write that arrives while the holding register is full is dropped and sets a sticky overflow flag.

The frame sequencer has five states:
- IDLE: the line is high.
- START: the start bit is on the line.
- DATA: the data bits are on the line.
- PARITY: the parity bit is on the line.
- STOP: the stop bits are on the line.

It has the following transitions:
- load: IDLE to START, when the holding register is full.
- start-done: START to DATA.
- data-done, parity on: DATA to PARITY.
- data-done, parity off: DATA to STOP.
- parity-done: PARITY to STOP.
- chain: STOP to START, when the last stop bit ends and the holding register is full.
- drain: STOP to IDLE, when the last stop bit ends and the holding register is empty.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset the line is high, `busy` is 0, `ready` is 1 and `ovf_flag` is 0.
- R2: A character written while the block is idle is visible in the holding register (`ready` low) at the next edge. The start bit (line low) begins one clock edge later.
- R3: Data bits follow the start bit with bit 0 first. Their count is `cfg_data_bits`: a value below 5 acts as 5 and a value above 9 acts as 9. Write-data bits above that count are not sent.
- R4: With `cfg_parity_en`=1, one parity bit follows the last data bit. `cfg_parity_odd`=0 selects even parity: the bit makes the number of ones over data and parity even. `cfg_parity_odd`=1 makes that number odd. With `cfg_parity_en`=0 no parity bit is sent.
- R5: The frame ends with one high stop bit when `cfg_two_stop`=0, or two when it is 1.
- R6: Every bit stays on the line for exactly `OVERSAMPLE` cycles in which `sample_tick` is high. While `sample_tick` is low, the line and the frame do not advance.
- R7: `busy` is high whenever the holding register or the shift register holds a character. It falls at the edge that ends the last stop bit when nothing is waiting.
- R8: `ready` is high exactly when the holding register is empty. A character that is waiting in the holding register moves to the shift register at the clock edge where the previous frame ends, or at the next edge if the block is idle.
- R9: If a character is waiting when the last stop bit ends, its start bit begins at that same edge, with no idle bit in between.
- R10: A write while the holding register is full is dropped, and `ovf_flag` is set. The flag stays set until a cycle with `ovf_clr` high. If a write is dropped in that same cycle, setting wins over clearing.
- R11: The framing inputs are captured when a character enters the shift register. A change made during its frame affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Oversampling enable; OVERSAMPLE ticks make one bit |
| wr_en | input | 1 | Write a character into the holding register |
| wr_data | input | DATA_MAX | Character to send, bit 0 sent first |
| cfg_data_bits | input | 4 | Number of data bits (clamped to 5..9) |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tx_line | output | 1 | Serial output line, idles high |
| busy | output | 1 | A character is held or being shifted |
| ready | output | 1 | Holding register empty; usable as an interrupt request |
| ovf_flag | output | 1 | Sticky flag: a write was dropped |

## Verification
The bench builds the block with `OVERSAMPLE`=4 and the default `DATA_MAX`=9. The short bit time makes it possible to sweep every data length from 5 to 9, both clamped out-of-range codes, all three parity choices and both stop lengths. Each configuration sends a pair of characters, the second waiting in the holding register so that chained frames are exercised. A monitor rebuilds each expected frame arithmetically and checks the line at every clock against the number of ticks delivered. This covers the exact bit length under both a continuous tick and an irregular tick pattern, as well as the overflow and mid-frame reconfiguration cases.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } stx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } stx_cfg_t;

    // Limit a requested data length to the supported window.
    function automatic logic [3:0] stx_clamp(input logic [3:0] n, input int lo, input int hi);
        if (int'(n) < lo) return 4'(lo);
        if (int'(n) > hi) return 4'(hi);
        return n;
    endfunction

endpackage

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_tick,
    output logic bit_done
);
    localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [TW-1:0] LAST = TW'(OVERSAMPLE - 1);

    logic [TW-1:0] cnt;

    assign bit_done = sample_tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || bit_done) begin
            cnt <= '0;
        end else if (sample_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: without a tick the bit phase does not move
    a_r6_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !sample_tick) |=> $stable(cnt));

endmodule

// File: rtl/stx_hold_reg.sv
module stx_hold_reg #(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    input  logic                ovf_clr,
    output logic                full,
    output logic [DATA_MAX-1:0] data_q,
    output logic                ovf_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            data_q   <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_en && !full) begin
                full   <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
            if (wr_en && full) begin
                ovf_flag <= 1'b1;
            end else if (ovf_clr) begin
                ovf_flag <= 1'b0;
            end
        end
    end

    // R8: the sequencer only takes a character that is present
    a_r8_take_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

    // R10: a dropped write raises the flag
    a_r10_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ovf_flag);

    // R10: the flag only falls through a clear
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R10: a dropped write leaves the held character intact
    a_r10_held_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> $stable(data_q));

endmodule

// File: rtl/stx_frame_fsm.sv
module stx_frame_fsm
    import stx_pkg::*;
#(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_done,
    input  logic                hold_full,
    input  logic [DATA_MAX-1:0] hold_data,
    input  stx_cfg_t            cfg_in,
    output logic                take,
    output logic                tx_line,
    output logic                idle
);
    stx_state_e          state, state_n;
    stx_cfg_t            cfg_q;
    logic [DATA_MAX-1:0] shreg;
    logic [3:0]          bit_idx;
    logic                stop_idx;
    logic                par_q;
    logic                par_calc;
    logic                last_data;
    logic                last_stop;

    assign last_data = (bit_idx == cfg_q.nbits - 4'd1);
    assign last_stop = !cfg_q.two_stop || stop_idx;
    assign take      = hold_full &&
                       ((state == ST_IDLE) ||
                        (state == ST_STOP && bit_done && last_stop));

    always_comb begin
        par_calc = cfg_in.par_odd;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(cfg_in.nbits)) par_calc = par_calc ^ hold_data[i];
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (hold_full) state_n = ST_START;
            ST_START:  if (bit_done) state_n = ST_DATA;
            ST_DATA:   if (bit_done && last_data)
                           state_n = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_n = ST_STOP;
            ST_STOP:   if (bit_done && last_stop)
                           state_n = hold_full ? ST_START : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cfg_q    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            par_q    <= 1'b0;
        end else if (take) begin
            shreg    <= hold_data;
            cfg_q    <= cfg_in;
            par_q    <= par_calc;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (bit_done) begin
            case (state)
                ST_DATA: begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 4'd1;
                end
                ST_STOP: stop_idx <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg[0];
            ST_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
        idle = (state == ST_IDLE);
    end

    // R6: no bit boundary, no movement of state or line
    a_r6_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !bit_done) |=> ($stable(state) && $stable(tx_line)));

    // R9: a waiting character chains straight into a start bit
    a_r9_chain_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && bit_done && last_stop && hold_full) |=> (state == ST_START && !tx_line));

    // R3: the data index never passes the captured length
    a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx < cfg_q.nbits));

    // R11: captured framing is frozen for the rest of the frame
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !take) |=> $stable(cfg_q));

    // R2: a load from idle drives the start bit at the next edge
    a_r2_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && hold_full) |=> !tx_line);

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import stx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MIN   = 5,
    parameter int DATA_MAX   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic [3:0]          cfg_data_bits,
    input  logic                cfg_parity_en,
    input  logic                cfg_parity_odd,
    input  logic                cfg_two_stop,
    input  logic                ovf_clr,
    output logic                tx_line,
    output logic                busy,
    output logic                ready,
    output logic                ovf_flag
);
    stx_cfg_t            cfg_now;
    logic                bit_done;
    logic                take;
    logic                fsm_idle;
    logic                hold_full;
    logic [DATA_MAX-1:0] hold_data;

    always_comb begin
        cfg_now.nbits    = stx_clamp(cfg_data_bits, DATA_MIN, DATA_MAX);
        cfg_now.par_en   = cfg_parity_en;
        cfg_now.par_odd  = cfg_parity_odd;
        cfg_now.two_stop = cfg_two_stop;
    end

    stx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (fsm_idle),
        .sample_tick (sample_tick),
        .bit_done    (bit_done)
    );

    stx_hold_reg #(.DATA_MAX(DATA_MAX)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .ovf_clr  (ovf_clr),
        .full     (hold_full),
        .data_q   (hold_data),
        .ovf_flag (ovf_flag)
    );

    stx_frame_fsm #(.DATA_MAX(DATA_MAX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_done  (bit_done),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg_in    (cfg_now),
        .take      (take),
        .tx_line   (tx_line),
        .idle      (fsm_idle)
    );

    assign busy  = !fsm_idle || hold_full;
    assign ready = !hold_full;

    // R7: the line can only be low while busy
    a_r7_low_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_line |-> busy);

endmodule

// File: tb/serial_tx_framer_test.sv
module serial_tx_framer_test;
    localparam int OS   = 4;
    localparam int DMAX = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            sample_tick = 1'b0;
    logic            wr_en = 1'b0;
    logic [DMAX-1:0] wr_data = '0;
    logic [3:0]      cfg_nb = 4'd8;
    logic            cfg_pe = 1'b0, cfg_po = 1'b0, cfg_ts = 1'b0;
    logic            ovf_clr = 1'b0;
    logic            tx_line, busy, ready, ovf_flag;

    serial_tx_framer #(.OVERSAMPLE(OS), .DATA_MIN(5), .DATA_MAX(DMAX)) uut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .wr_en(wr_en), .wr_data(wr_data),
        .cfg_data_bits(cfg_nb), .cfg_parity_en(cfg_pe),
        .cfg_parity_odd(cfg_po), .cfg_two_stop(cfg_ts),
        .ovf_clr(ovf_clr),
        .tx_line(tx_line), .busy(busy), .ready(ready), .ovf_flag(ovf_flag)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected-frame queue: data and packed framing {ts,po,pe,nb[3:0]}
    int qd[$];
    int qc[$];

    function automatic int clampn(input int n);
        return (n < 5) ? 5 : ((n > 9) ? 9 : n);
    endfunction

    // Monitor state
    bit eb[16];
    int flen = 0, c = 0, mism = 0, m_act = 0, m_exp = 0, busy_bad = 0;
    bit in_frame = 0, junk = 0, mon_on = 0;
    int tmode = 0, tcnt = 0;

    task automatic build(input int d, input int cf);
        int n, idx, p;
        n = clampn(cf & 15);
        eb[0] = 1'b0;
        p = (cf >> 5) & 1;
        for (int i = 0; i < n; i++) begin
            eb[1 + i] = bit'((d >> i) & 1);
            p = p ^ ((d >> i) & 1);
        end
        idx = 1 + n;
        if ((cf >> 4) & 1) begin
            eb[idx] = bit'(p);
            idx++;
        end
        eb[idx] = 1'b1;
        idx++;
        if ((cf >> 6) & 1) begin
            eb[idx] = 1'b1;
            idx++;
        end
        flen = idx;
    endtask

    always @(negedge clk) begin
        bit tk;
        if (mon_on) begin
            if (in_frame) begin
                if (c < flen * OS) begin
                    // R6: the bit on the line is fixed by the ticks delivered
                    if (tx_line !== eb[c / OS] && mism == 0) begin
                        mism  = 1;
                        m_act = int'(tx_line);
                        m_exp = int'(eb[c / OS]);
                    end
                    if (busy !== 1'b1) busy_bad++;
                end
                if (c == flen * OS) begin
                    chk(mism == 0, "R3 R4 R5 R6 frame bits", m_act, m_exp);
                    chk(busy_bad == 0, "R7 busy during frame", busy_bad, 0);
                    in_frame = 0;
                    if (qd.size() > 0) begin
                        chk(tx_line === 1'b0, "R9 chained start", int'(tx_line), 0);
                    end else begin
                        chk(busy === 1'b0, "R7 busy falls at frame end", int'(busy), 0);
                    end
                end
            end
            if (junk && tx_line === 1'b1) junk = 0;
            if (!in_frame && !junk && tx_line === 1'b0) begin
                if (qd.size() == 0) begin
                    chk(1'b0, "R2 unexpected frame", 1, 0);
                    junk = 1;
                end else begin
                    build(qd.pop_front(), qc.pop_front());
                    in_frame = 1;
                    c = 0;
                    mism = 0;
                    busy_bad = 0;
                end
            end
        end
        tcnt++;
        tk = (tmode == 0) ? 1'b1 : ((tcnt % 3 == 0) || (tcnt % 7 == 0));
        sample_tick = tk;
        if (in_frame && tk) c++;
    end

    function automatic int cur_cfg();
        return int'(cfg_nb) | (int'(cfg_pe) << 4) | (int'(cfg_po) << 5) | (int'(cfg_ts) << 6);
    endfunction

    task automatic wr(input int d, input bit exp_ok);
        @(negedge clk);
        chk(ready === exp_ok, "R8 ready before write", int'(ready), int'(exp_ok));
        wr_en   = 1'b1;
        wr_data = DMAX'(d);
        if (exp_ok) begin
            qd.push_back(d & ((1 << DMAX) - 1));
            qc.push_back(cur_cfg());
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy === 1'b1 || in_frame);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(input int nb, input int pm, input int ts);
        cfg_nb = 4'(nb);
        cfg_pe = (pm != 0);
        cfg_po = (pm == 2);
        cfg_ts = 1'(ts);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int nbl[7];
        int d1;
        nbl = '{3, 5, 6, 7, 8, 9, 15};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_line === 1'b1, "R1 line idle high", int'(tx_line), 1);
        chk(busy === 1'b0, "R1 busy low", int'(busy), 0);
        chk(ready === 1'b1, "R1 ready high", int'(ready), 1);
        chk(ovf_flag === 1'b0, "R1 overflow clear", int'(ovf_flag), 0);
        rst_n = 1'b1;
        mon_on = 1;
        repeat (2) @(negedge clk);

        // R2 / R8: load timing from idle, 8 data bits, no parity, one stop
        set_cfg(8, 0, 0);
        wr_en = 1'b1;
        wr_data = 9'h0A7;
        qd.push_back(9'h0A7);
        qc.push_back(cur_cfg());
        @(negedge clk);
        wr_en = 1'b0;
        chk(ready === 1'b0, "R8 holding full after write", int'(ready), 0);
        chk(tx_line === 1'b1, "R2 line still high at write edge", int'(tx_line), 1);
        chk(busy === 1'b1, "R7 busy with held character", int'(busy), 1);
        @(negedge clk);
        chk(tx_line === 1'b0, "R2 start bit one edge later", int'(tx_line), 0);
        chk(ready === 1'b1, "R8 holding freed on load", int'(ready), 1);
        wait_idle();

        // R3 R4 R5 R9: sweep of lengths (incl. clamped codes), parity, stops
        foreach (nbl[k]) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    set_cfg(nbl[k], pm, ts);
                    d1 = (nbl[k] * 37 + pm * 11 + ts * 5 + 'h0A5) & 'h1FF;
                    wr(d1, 1'b1);
                    wr(~d1 & 'h1FF, 1'b1);
                    wait_idle();
                end
            end
        end

        // R6: irregular tick pattern
        tmode = 1;
        set_cfg(7, 2, 1);
        wr('h05A, 1'b1);
        wr('h133, 1'b1);
        wait_idle();
        set_cfg(9, 1, 0);
        wr('h1C3, 1'b1);
        wr('h02E, 1'b1);
        wait_idle();
        tmode = 0;

        // R11: framing change after load applies only to the next character
        set_cfg(8, 1, 0);
        wr('h0F1, 1'b1);
        @(negedge clk);
        set_cfg(5, 2, 1);
        wait_idle();
        wr('h1AB, 1'b1);
        wait_idle();

        // R10: write while full is dropped, flag sticky, then cleared
        set_cfg(6, 0, 0);
        wr('h015, 1'b1);
        wr('h02A, 1'b1);
        wr('h03F, 1'b0);
        chk(ovf_flag === 1'b1, "R10 overflow set", int'(ovf_flag), 1);
        wait_idle();
        chk(ovf_flag === 1'b1, "R10 overflow sticky", int'(ovf_flag), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf_flag === 1'b0, "R10 overflow cleared", int'(ovf_flag), 0);

        repeat (20) @(negedge clk);
        chk(qd.size() == 0, "R2 every accepted character sent", qd.size(), 0);
        chk(tx_line === 1'b1 && busy === 1'b0, "R1 idle after traffic", int'(tx_line), 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule